// File: doc/BRIEF.md
# Dual-Channel ATR GPIO Controller

This block drives 24 general-purpose pins from one of three sources. Each of two radio channels reports a 2-bit automatic transmit/receive (ATR) state. In combined ATR mode, the two states together pick one of sixteen stored pin patterns. In classic ATR mode, a source bit picks one channel, and that channel's state alone picks one of four patterns reserved for it. In manual mode, the pins follow one output register. A direction register sets each pin as an output or an input. A read-only register returns the level on each pin.

The pins come from two physical 12-pin ports and are handled as one 24-bit port. Every register uses the same split layout for the pins. The low port sits in word bits [11:0] and the high port sits in word bits [27:16]. A plain register bus with single-cycle writes and combinational reads sets up and reads back all storage.

Top module: `atr_gpio_ctrl`

## Requirements
- R1: In every register word, pin p (0..11) is bit p and pin p (12..23) is bit p+4. The pin ports are contiguous [23:0].
- R2: Word bits [15:12] and [31:28] read as zero and are dropped on write.
- R3: After a synchronous active-low reset, gpio_out and gpio_oe are zero, all sixteen pattern entries read zero, and the mode, classic and source fields read zero.
- R4: When the mode register (address 0x10, bit 0) is 0, gpio_out follows the manual register (0x12).
- R5: gpio_oe follows the direction register (0x13): 1 drives the pin and 0 makes it an input.
- R6: Address 0x14 reads back gpio_in in the R1 layout. A write to 0x14 changes nothing.
- R7: When mode bit 0 is 1 and the classic bit (0x11 bit 0) is 0, gpio_out is the entry at address {atr_st1, atr_st0}. Entries live at 0x0..0xF.
- R8: When mode bit 0 is 1 and the classic bit is 1, the source bit (0x11 bit 1) chooses the channel. Channel 0 uses entry {2'b00, atr_st0} and channel 1 uses entry {2'b01, atr_st1}. The state of the other channel has no effect.
- R9: gpio_out and gpio_oe are registered. A register write captured at one clock edge reaches the pins at the next edge. An ATR state present before an edge appears on the pins at that edge.
- R10: The mode and control registers read back their stored bits, with all other bits zero. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| atr_st0 | input | 2 | ATR state of channel 0 (0 idle, 1 rx, 2 tx, 3 duplex) |
| atr_st1 | input | 2 | ATR state of channel 1 |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| gpio_in | input | 24 | Pin input levels |
| gpio_out | output | 24 | Registered pin output values |
| gpio_oe | output | 24 | Registered pin output enables |

## Verification
The assertions expect both ATR states to be clean, synchronous inputs that change only between clock edges. They also expect that no write is in flight when the chosen source is checked. The bench drives every input at the falling edge and holds it through the next rising edge, so each write and each state change is seen by exactly one capturing edge. The bench compares pins only after the edge that R9 names, and it checks the pins just before that edge as well. This shows that nothing reaches the pins early.

// File: rtl/atr_gpio_pkg.sv
// Package: shared widths, register addresses and the pin/word layout
// conversions for the dual-channel ATR GPIO controller.
// Assumes 24 pins split into two 12-pin ports.
package atr_gpio_pkg;

    localparam int PIN_W    = 24;
    localparam int PORT_W   = 12;
    localparam int HI_LSB   = 16;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int ST_W     = 2;
    localparam int ENTRIES  = 16;
    localparam int IDX_W    = $clog2(ENTRIES);

    localparam logic [ADDR_W-1:0] A_MODE   = 5'h10;
    localparam logic [ADDR_W-1:0] A_CTRL   = 5'h11;
    localparam logic [ADDR_W-1:0] A_MANUAL = 5'h12;
    localparam logic [ADDR_W-1:0] A_DIR    = 5'h13;
    localparam logic [ADDR_W-1:0] A_INPUT  = 5'h14;

    typedef enum logic { DRIVE_MANUAL = 1'b0, DRIVE_ATR = 1'b1 } drive_mode_e;

    // Place 24 pin bits into the split register layout.
    function automatic logic [WORD_W-1:0] pins_to_word(input logic [PIN_W-1:0] p);
        logic [WORD_W-1:0] w;
        w = '0;
        w[PORT_W-1:0]               = p[PORT_W-1:0];
        w[HI_LSB+PORT_W-1:HI_LSB]   = p[PIN_W-1:PORT_W];
        return w;
    endfunction

    // Extract 24 pin bits from the split register layout.
    function automatic logic [PIN_W-1:0] word_to_pins(input logic [WORD_W-1:0] w);
        return {w[HI_LSB+PORT_W-1:HI_LSB], w[PORT_W-1:0]};
    endfunction

endpackage

// File: rtl/atr_gpio_regfile.sv
// Register file: pattern table, mode, classic/source control, manual value
// and direction. Writes take one cycle; reads are combinational.
// Assumes that bus_addr is stable while bus_we is high.
module atr_gpio_regfile
    import atr_gpio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    input  logic [PIN_W-1:0]     gpio_in,
    output logic [PIN_W-1:0]     tbl [ENTRIES],
    output drive_mode_e          mode,
    output logic                 classic,
    output logic                 src_sel,
    output logic [PIN_W-1:0]     manual_val,
    output logic [PIN_W-1:0]     dir_val
);

    localparam logic [ADDR_W-1:0] TBL_LIMIT = ADDR_W'(ENTRIES);

    logic [PIN_W-1:0] wpins;
    assign wpins = word_to_pins(bus_wdata);

    // One write-enabled register per pattern entry.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                tbl[e] <= '0;
            else if (bus_we && bus_addr == ADDR_W'(e))
                tbl[e] <= wpins;
        end
    end

    // Control registers; writes to the input address are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode       <= DRIVE_MANUAL;
            classic    <= 1'b0;
            src_sel    <= 1'b0;
            manual_val <= '0;
            dir_val    <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                A_MODE:   mode <= drive_mode_e'(bus_wdata[0]);
                A_CTRL:   begin classic <= bus_wdata[0]; src_sel <= bus_wdata[1]; end
                A_MANUAL: manual_val <= wpins;
                A_DIR:    dir_val <= wpins;
                default:  ;
            endcase
        end
    end

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr < TBL_LIMIT)
            bus_rdata = pins_to_word(tbl[bus_addr[IDX_W-1:0]]);
        else case (bus_addr)
            A_MODE:   bus_rdata[0] = mode;
            A_CTRL:   bus_rdata[1:0] = {src_sel, classic};
            A_MANUAL: bus_rdata = pins_to_word(manual_val);
            A_DIR:    bus_rdata = pins_to_word(dir_val);
            A_INPUT:  bus_rdata = pins_to_word(gpio_in);
            default:  bus_rdata = '0;
        endcase
    end

    // R2: gap and top bits of every read word stay zero.
    a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[15:12] == 4'h0 && bus_rdata[31:28] == 4'h0);

endmodule

// File: rtl/atr_gpio_select.sv
// Source selector: picks manual, combined-ATR or classic-ATR pin values.
// Purely combinational; assumes ENTRIES is 16 (two 2-bit states).
module atr_gpio_select
    import atr_gpio_pkg::*;
(
    input  drive_mode_e          mode,
    input  logic                 classic,
    input  logic                 src_sel,
    input  logic [ST_W-1:0]      st0,
    input  logic [ST_W-1:0]      st1,
    input  logic [PIN_W-1:0]     tbl [ENTRIES],
    input  logic [PIN_W-1:0]     manual_val,
    output logic [PIN_W-1:0]     pins_next
);

    logic [IDX_W-1:0] idx;

    // Form the table index for the active ATR scheme.
    always_comb begin
        if (!classic)
            idx = {st1, st0};
        else if (src_sel)
            idx = {2'b01, st1};
        else
            idx = {2'b00, st0};
    end

    // Choose between the manual value and the table entry.
    always_comb begin
        pins_next = (mode == DRIVE_ATR) ? tbl[idx] : manual_val;
    end

endmodule

// File: rtl/atr_gpio_ctrl.sv
// Top: dual-channel ATR GPIO controller. It registers the selected pin
// values and the direction register onto gpio_out and gpio_oe.
// Assumes atr_st0/atr_st1 are synchronous to clk.
module atr_gpio_ctrl
    import atr_gpio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ST_W-1:0]      atr_st0,
    input  logic [ST_W-1:0]      atr_st1,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    input  logic [PIN_W-1:0]     gpio_in,
    output logic [PIN_W-1:0]     gpio_out,
    output logic [PIN_W-1:0]     gpio_oe
);

    logic [PIN_W-1:0] tbl [ENTRIES];
    drive_mode_e      mode;
    logic             classic, src_sel;
    logic [PIN_W-1:0] manual_val, dir_val, pins_next;

    atr_gpio_regfile u_regs (
        .clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata, .gpio_in,
        .tbl, .mode, .classic, .src_sel, .manual_val, .dir_val
    );

    atr_gpio_select u_sel (
        .mode, .classic, .src_sel, .st0(atr_st0), .st1(atr_st1),
        .tbl, .manual_val, .pins_next
    );

    // Output registers for pin values and enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gpio_out <= '0;
            gpio_oe  <= '0;
        end else begin
            gpio_out <= pins_next;
            gpio_oe  <= dir_val;
        end
    end

    logic [PIN_W-1:0] chk_comb, chk_ch0;
    assign chk_comb = tbl[{atr_st1, atr_st0}];
    assign chk_ch0  = tbl[{2'b00, atr_st0}];

    // R4: manual mode drives the manual register one edge later.
    a_r4_manual_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DRIVE_MANUAL) |=> gpio_out == $past(manual_val));

    // R5: enables follow the direction register one edge later.
    a_r5_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> gpio_oe == $past(dir_val));

    // R7: combined mode uses the joint index.
    a_r7_combined_index: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DRIVE_ATR && !classic) |=> gpio_out == $past(chk_comb));

    // R8: classic mode with source 0 uses channel 0's four entries.
    a_r8_classic_ch0: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DRIVE_ATR && classic && !src_sel) |=> gpio_out == $past(chk_ch0));

endmodule

// File: tb/atr_gpio_ctrl_bench.sv
module atr_gpio_ctrl_bench;
    import atr_gpio_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        atr_st0 = '0, atr_st1 = '0;
    logic              bus_we = 1'b0;
    logic [4:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [23:0]       gpio_in = '0;
    logic [23:0]       gpio_out, gpio_oe;

    atr_gpio_ctrl u_atr_gpio_ctrl (
        .clk, .rst_n, .atr_st0, .atr_st1, .bus_we, .bus_addr, .bus_wdata,
        .bus_rdata, .gpio_in, .gpio_out, .gpio_oe
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        string       req;
        int          kind;   // 0 gpio_out, 1 gpio_oe, 2 bus_rdata
        logic [31:0] exp;
    } item_t;

    item_t q[$];
    event  ev_chk;
    int    n_vec = 0, n_bad = 0;
    bit    done = 0;

    // Monitor: pop expected items and compare with the ports.
    initial forever begin
        @(ev_chk);
        #1;
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
                0: act = {8'h0, gpio_out};
                1: act = {8'h0, gpio_oe};
                default: act = bus_rdata;
            endcase
            n_vec++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic expect_item(string req, int kind, logic [31:0] exp);
        item_t it;
        it.req = req; it.kind = kind; it.exp = exp;
        q.push_back(it);
        -> ev_chk;
        #2;
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_expect(string req, logic [4:0] a, logic [31:0] exp);
        bus_addr = a;
        expect_item(req, 2, exp);
    endtask

    function automatic logic [23:0] pat(int i);
        return 24'h0F1E2D ^ (24'h010203 * 24'(i + 1));
    endfunction

    function automatic logic [31:0] lay(logic [23:0] p);
        return {4'h0, p[23:12], 4'h0, p[11:0]};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 reset state
        expect_item("R3", 0, 32'h0);
        expect_item("R3", 1, 32'h0);
        rd_expect("R3", 5'h07, 32'h0);
        rd_expect("R3", 5'h10, 32'h0);
        rd_expect("R3", 5'h11, 32'h0);

        // R2/R4 manual value, unused bits dropped
        wr(5'h12, 32'hFFFF_FFFF);
        rd_expect("R2", 5'h12, 32'h0FFF_0FFF);
        expect_item("R9", 0, 32'h0);          // not yet on pins
        @(negedge clk);
        expect_item("R4", 0, 32'h00FF_FFFF);
        wr(5'h12, 32'h0ABC_0123);
        @(negedge clk);
        expect_item("R1", 0, 32'h00AB_C123);

        // R5 direction
        wr(5'h13, 32'h0F0F_00FF);
        @(negedge clk);
        expect_item("R5", 1, 32'h00F0_F0FF);

        // R6 input readback and write ignored
        gpio_in = 24'h123456;
        rd_expect("R6", 5'h14, 32'h0123_0456);
        wr(5'h14, 32'h0FFF_0FFF);
        rd_expect("R6", 5'h14, 32'h0123_0456);
        @(negedge clk);
        expect_item("R6", 0, 32'h00AB_C123);
        expect_item("R6", 1, 32'h00F0_F0FF);

        // R10 unmapped and control readback
        rd_expect("R10", 5'h1F, 32'h0);

        // Fill pattern table
        for (int i = 0; i < 16; i++) wr(5'(i), lay(pat(i)));
        rd_expect("R1", 5'h09, lay(pat(9)));

        // R7 combined mode
        atr_st0 = 2'd2; atr_st1 = 2'd1;
        wr(5'h10, 32'h1);
        rd_expect("R10", 5'h10, 32'h1);
        @(negedge clk);
        expect_item("R7", 0, {8'h0, pat(6)});
        atr_st0 = 2'd3; atr_st1 = 2'd3;
        expect_item("R9", 0, {8'h0, pat(6)});  // before edge
        @(negedge clk);
        expect_item("R7", 0, {8'h0, pat(15)});
        atr_st0 = 2'd0; atr_st1 = 2'd2;
        @(negedge clk);
        expect_item("R7", 0, {8'h0, pat(8)});

        // R8 classic, source channel 0
        wr(5'h11, 32'hFFFF_FFFD);
        rd_expect("R10", 5'h11, 32'h1);
        atr_st0 = 2'd3; atr_st1 = 2'd0;
        @(negedge clk);
        expect_item("R8", 0, {8'h0, pat(3)});
        atr_st1 = 2'd2;
        @(negedge clk);
        expect_item("R8", 0, {8'h0, pat(3)});
        // R8 classic, source channel 1
        wr(5'h11, 32'h3);
        atr_st1 = 2'd2; atr_st0 = 2'd1;
        @(negedge clk);
        expect_item("R8", 0, {8'h0, pat(6)});
        atr_st0 = 2'd3;
        @(negedge clk);
        expect_item("R8", 0, {8'h0, pat(6)});

        // Back to manual mode
        wr(5'h10, 32'h0);
        @(negedge clk);
        expect_item("R4", 0, 32'h00AB_C123);

        // R3 reset clears again
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        expect_item("R3", 0, 32'h0);
        expect_item("R3", 1, 32'h0);
        rd_expect("R3", 5'h0F, 32'h0);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule